// File: doc/BRIEF.md
# Configurable Four-Face Logic Tile

This block is one cell of a small two-dimensional programmable fabric. It has four faces (north, east, south, west). Each face is set by configuration to receive a signal from a neighbour or to drive one. Inside the tile a function unit works in one of three modes:

- any two-input Boolean function, held as a four-entry truth table;
- a 2:1 multiplexer whose select comes from a local bus;
- a D flip-flop with a synchronous clear.

Every output face is driven either by the function unit or by a signal passed straight through from another face. The tile can therefore serve as logic, as storage or as a wire. The tile also has a small local-bus port. Through a pass gate it can read a bus, which gives the multiplexer select. With the pass gate and the driver both enabled it can write the function unit's result onto a bus.

The whole behaviour comes from one configuration word. That word is loaded through a parallel write port and takes effect at the clock edge on which it is written. When a setting is illegal, the tile raises an error flag and keeps the affected output quiet. The illegal settings are: an output face fed from itself or from another output face, a bus both read and written, and the reserved function mode.

Top module: `fab_tile`

## Requirements
- R1: While reset is asserted and after its release, with no configuration written, every face is an input (`face_oe` = 0, `face_out` = 0), no bus is driven (`bus_oe` = 0, `bus_out` = 0) and `cfg_err` is 0.
- R2: A configuration word presented with `cfg_we` high is loaded at that rising clock edge and governs the outputs from then on. With `cfg_we` low the stored word is kept, whatever `cfg_wdata` carries. Field positions (default two buses, 31 bits):
  - [3:0] truth table;
  - [5:4] mode;
  - [7:6] operand A face;
  - [9:8] operand B face;
  - [10] multiplexer bus number;
  - [12:11] bus pass gates;
  - [14:13] bus drivers;
  - for face f (north 0, east 1, south 2, west 3), bit 15+4f is the direction (1 = output) and bits 18+4f:16+4f are the source.
- R3: In mode 00 the function result is truth-table bit {B,A}, where A and B are the inputs of the faces chosen by the operand fields.
- R4: In mode 01 the function result is B when the select is 1 and A when it is 0. The select is the input of the bus named by the bus-number field if that bus's pass gate is on, and 0 otherwise.
- R5: In mode 10 the result is a register that loads A at each rising edge. A high `clr` at an edge sets the register to 0 whatever the mode and input. In the other modes the register keeps its value.
- R6: A face whose direction bit is 0 has `face_oe` = 0 and `face_out` = 0. A face whose direction bit is 1 has `face_oe` = 1.
- R7: For an output face, source bit 2 = 1 selects the function result. Source bit 2 = 0 selects the input arriving on the face numbered by source bits 1:0.
- R8: An output face whose pass-through source is itself, or is another output face, drives 0 and sets `cfg_err`.
- R9: Bus i is written when its pass gate and driver are both on: `bus_oe[i]` = 1 and `bus_out[i]` equals the function result. If that bus is also being read as the multiplexer select, the write is suppressed and `cfg_err` is set.
- R10: Mode 11 is reserved: the function result is 0 and `cfg_err` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_wdata | input | CFGW (31) | Configuration word |
| clr | input | 1 | Synchronous clear of the flip-flop, active high |
| face_in | input | 4 | Signals arriving on faces N, E, S, W (bits 0..3) |
| face_out | output | 4 | Values driven onto the faces |
| face_oe | output | 4 | Face drive enables (1 = face is an output) |
| bus_in | input | NBUS (2) | Local bus values seen by the tile |
| bus_out | output | NBUS (2) | Values the tile writes onto the buses |
| bus_oe | output | NBUS (2) | Bus drive enables |
| cfg_err | output | 1 | Configuration conflict flag |

## Verification
- **Truth-table mode.** Every one of the 16 truth tables is applied against all four operand pairs. The XOR and AND tables that form a half adder are also checked by name. Together these tell a wrong table index or swapped operands apart from a correct cell.
- **Routing.** Pass-through is swept over every output face, every source number and all 16 face-input patterns. This separates correct routing from self-selection and off-by-one face numbering.
- **Multiplexer mode.** All combinations of bus number, pass gates, bus values and operands are tried. This exposes a select read from the wrong bus or read through a closed gate.
- **Storage and bus port.** A clocked sequence checks capture, clear priority and hold across mode changes. Directed bus cases cover a normal write, a driver without its pass gate, and a read-write clash.

// File: rtl/fab_tile_pkg.sv
package fab_tile_pkg;

  localparam int NFACE = 4;
  localparam int SRCW  = 3;

  typedef enum logic [1:0] {
    FU_LUT2 = 2'b00,
    FU_MUX2 = 2'b01,
    FU_DFF  = 2'b10,
    FU_RSVD = 2'b11
  } fu_mode_e;

endpackage

// File: rtl/fab_tile_cfg.sv
module fab_tile_cfg
  import fab_tile_pkg::*;
#(
  parameter int NBUS  = 2,
  parameter int BSELW = 1,
  parameter int CFGW  = 31
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cfg_we,
  input  logic [CFGW-1:0]            cfg_wdata,
  output logic [3:0]                 lut,
  output fu_mode_e                   mode,
  output logic [1:0]                 opa_sel,
  output logic [1:0]                 opb_sel,
  output logic [BSELW-1:0]           mux_bus,
  output logic [NBUS-1:0]            pass,
  output logic [NBUS-1:0]            drv,
  output logic [NFACE-1:0]           dir,
  output logic [NFACE-1:0][SRCW-1:0] src
);

  localparam int LUT_LSB  = 0;
  localparam int MODE_LSB = 4;
  localparam int OPA_LSB  = 6;
  localparam int OPB_LSB  = 8;
  localparam int MBUS_LSB = 10;
  localparam int PASS_LSB = MBUS_LSB + BSELW;
  localparam int DRV_LSB  = PASS_LSB + NBUS;
  localparam int FACE_LSB = DRV_LSB + NBUS;
  localparam int FACE_W   = 1 + SRCW;

  logic [CFGW-1:0] cfg_q;
  logic [CFGW-1:0] cfg_d;

  // next-state: explicit load enable
  always_comb begin
    cfg_d = cfg_q;
    if (cfg_we) cfg_d = cfg_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cfg_d;
  end

  assign lut     = cfg_q[LUT_LSB +: 4];
  assign mode    = fu_mode_e'(cfg_q[MODE_LSB +: 2]);
  assign opa_sel = cfg_q[OPA_LSB +: 2];
  assign opb_sel = cfg_q[OPB_LSB +: 2];
  assign mux_bus = cfg_q[MBUS_LSB +: BSELW];
  assign pass    = cfg_q[PASS_LSB +: NBUS];
  assign drv     = cfg_q[DRV_LSB +: NBUS];

  for (genvar f = 0; f < NFACE; f++) begin : g_face_field
    assign dir[f] = cfg_q[FACE_LSB + FACE_W*f];
    assign src[f] = cfg_q[FACE_LSB + FACE_W*f + 1 +: SRCW];
  end

  p_cfg_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> cfg_q == $past(cfg_wdata));
  p_cfg_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> $stable(cfg_q));

endmodule

// File: rtl/fab_tile_fu.sv
module fab_tile_fu
  import fab_tile_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  fu_mode_e   mode,
  input  logic [3:0] lut,
  input  logic       op_a,
  input  logic       op_b,
  input  logic       mux_sel,
  output logic       fu_y
);

  logic q_r;
  logic q_d;

  // storage element: clear has priority, capture only in DFF mode
  always_comb begin
    q_d = q_r;
    if (clr)                  q_d = 1'b0;
    else if (mode == FU_DFF)  q_d = op_a;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_r <= 1'b0;
    else        q_r <= q_d;
  end

  always_comb begin
    unique case (mode)
      FU_LUT2: fu_y = lut[{op_b, op_a}];
      FU_MUX2: fu_y = mux_sel ? op_b : op_a;
      FU_DFF:  fu_y = q_r;
      default: fu_y = 1'b0;
    endcase
  end

  p_clear_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !q_r);
  p_dff_capture_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && mode == FU_DFF) |=> q_r == $past(op_a));
  p_dff_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && mode != FU_DFF) |=> $stable(q_r));
  p_rsvd_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mode == FU_RSVD |-> !fu_y);

endmodule

// File: rtl/fab_tile_bus.sv
module fab_tile_bus
  import fab_tile_pkg::*;
#(
  parameter int NBUS  = 2,
  parameter int BSELW = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  fu_mode_e         mode,
  input  logic [BSELW-1:0] mux_bus,
  input  logic [NBUS-1:0]  pass,
  input  logic [NBUS-1:0]  drv,
  input  logic [NBUS-1:0]  bus_in,
  input  logic             fu_y,
  output logic             mux_sel,
  output logic [NBUS-1:0]  bus_out,
  output logic [NBUS-1:0]  bus_oe,
  output logic             bus_err
);

  logic [NBUS-1:0] rd;
  logic [NBUS-1:0] wr_req;
  logic [NBUS-1:0] clash;

  for (genvar i = 0; i < NBUS; i++) begin : g_bus
    assign rd[i]      = (mode == FU_MUX2) && (mux_bus == BSELW'(i)) && pass[i];
    assign wr_req[i]  = pass[i] && drv[i];
    assign clash[i]   = rd[i] && wr_req[i];
    assign bus_oe[i]  = wr_req[i] && !clash[i];
    assign bus_out[i] = bus_oe[i] && fu_y;

    p_one_op_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_oe[i] && rd[i]));
  end

  assign mux_sel = |(rd & bus_in);
  assign bus_err = |clash;

  p_read_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rd));

endmodule

// File: rtl/fab_tile_route.sv
module fab_tile_route
  import fab_tile_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NFACE-1:0]           dir,
  input  logic [NFACE-1:0][SRCW-1:0] src,
  input  logic [NFACE-1:0]           face_in,
  input  logic                       fu_y,
  output logic [NFACE-1:0]           face_out,
  output logic [NFACE-1:0]           face_oe,
  output logic                       route_err
);

  logic [NFACE-1:0] bad;

  for (genvar f = 0; f < NFACE; f++) begin : g_face
    logic [1:0] idx;
    logic       use_fu;
    logic       val;

    assign idx    = src[f][1:0];
    assign use_fu = src[f][2];
    assign bad[f] = dir[f] && !use_fu && ((idx == 2'(f)) || dir[idx]);
    assign val    = use_fu ? fu_y : face_in[idx];

    assign face_oe[f]  = dir[f];
    assign face_out[f] = dir[f] && !bad[f] && val;

    p_input_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !face_oe[f] |-> !face_out[f]);
    p_self_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (dir[f] && !use_fu && idx == 2'(f)) |-> (!face_out[f] && route_err));
  end

  assign route_err = |bad;

endmodule

// File: rtl/fab_tile.sv
module fab_tile
  import fab_tile_pkg::*;
#(
  parameter int NBUS = 2,
  localparam int BSELW = (NBUS > 1) ? $clog2(NBUS) : 1,
  localparam int CFGW  = 10 + BSELW + 2*NBUS + (1 + SRCW)*NFACE
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [CFGW-1:0]  cfg_wdata,
  input  logic             clr,
  input  logic [3:0]       face_in,
  output logic [3:0]       face_out,
  output logic [3:0]       face_oe,
  input  logic [NBUS-1:0]  bus_in,
  output logic [NBUS-1:0]  bus_out,
  output logic [NBUS-1:0]  bus_oe,
  output logic             cfg_err
);

  logic [3:0]                 lut;
  fu_mode_e                   mode;
  logic [1:0]                 opa_sel;
  logic [1:0]                 opb_sel;
  logic [BSELW-1:0]           mux_bus;
  logic [NBUS-1:0]            pass;
  logic [NBUS-1:0]            drv;
  logic [NFACE-1:0]           dir;
  logic [NFACE-1:0][SRCW-1:0] src;
  logic                       fu_y;
  logic                       mux_sel;
  logic                       bus_err;
  logic                       route_err;

  fab_tile_cfg #(.NBUS(NBUS), .BSELW(BSELW), .CFGW(CFGW)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_wdata (cfg_wdata),
    .lut       (lut),
    .mode      (mode),
    .opa_sel   (opa_sel),
    .opb_sel   (opb_sel),
    .mux_bus   (mux_bus),
    .pass      (pass),
    .drv       (drv),
    .dir       (dir),
    .src       (src)
  );

  fab_tile_fu u_fu (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (clr),
    .mode    (mode),
    .lut     (lut),
    .op_a    (face_in[opa_sel]),
    .op_b    (face_in[opb_sel]),
    .mux_sel (mux_sel),
    .fu_y    (fu_y)
  );

  fab_tile_bus #(.NBUS(NBUS), .BSELW(BSELW)) u_bus (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode    (mode),
    .mux_bus (mux_bus),
    .pass    (pass),
    .drv     (drv),
    .bus_in  (bus_in),
    .fu_y    (fu_y),
    .mux_sel (mux_sel),
    .bus_out (bus_out),
    .bus_oe  (bus_oe),
    .bus_err (bus_err)
  );

  fab_tile_route u_route (
    .clk       (clk),
    .rst_n     (rst_n),
    .dir       (dir),
    .src       (src),
    .face_in   (face_in),
    .fu_y      (fu_y),
    .face_out  (face_out),
    .face_oe   (face_oe),
    .route_err (route_err)
  );

  assign cfg_err = route_err || bus_err || (mode == FU_RSVD);

  p_err_on_rsvd_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mode == FU_RSVD |-> cfg_err);

endmodule

// File: tb/fab_tile_tb.sv
module fab_tile_tb;

  localparam int CFGW = 31;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            cfg_we;
  logic [CFGW-1:0] cfg_wdata;
  logic            clr;
  logic [3:0]      face_in;
  logic [3:0]      face_out;
  logic [3:0]      face_oe;
  logic [1:0]      bus_in;
  logic [1:0]      bus_out;
  logic [1:0]      bus_oe;
  logic            cfg_err;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  fab_tile u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_wdata (cfg_wdata),
    .clr       (clr),
    .face_in   (face_in),
    .face_out  (face_out),
    .face_oe   (face_oe),
    .bus_in    (bus_in),
    .bus_out   (bus_out),
    .bus_oe    (bus_oe),
    .cfg_err   (cfg_err)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // builds a configuration word from its fields (layout of R2)
  function automatic logic [CFGW-1:0] mk(input logic [3:0] lut, input logic [1:0] mode,
                                         input logic [1:0] opa, input logic [1:0] opb,
                                         input logic mb, input logic [1:0] pass,
                                         input logic [1:0] drv, input logic [3:0] dir,
                                         input logic [11:0] src);
    logic [CFGW-1:0] c;
    c        = '0;
    c[3:0]   = lut;
    c[5:4]   = mode;
    c[7:6]   = opa;
    c[9:8]   = opb;
    c[10]    = mb;
    c[12:11] = pass;
    c[14:13] = drv;
    for (int f = 0; f < 4; f++) begin
      c[15 + 4*f]         = dir[f];
      c[16 + 4*f +: 3]    = src[3*f +: 3];
    end
    return c;
  endfunction

  task automatic write_cfg(input logic [CFGW-1:0] w);
    @(negedge clk);
    cfg_wdata = w;
    cfg_we    = 1'b1;
    @(negedge clk);
    cfg_we    = 1'b0;
  endtask

  // south face as output showing the function result, operands A=north B=east
  function automatic logic [CFGW-1:0] fu_cfg(input logic [3:0] lut, input logic [1:0] mode,
                                             input logic mb, input logic [1:0] pass,
                                             input logic [1:0] drv);
    return mk(lut, mode, 2'd0, 2'd1, mb, pass, drv, 4'b0100, 12'b000_100_000_000);
  endfunction

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic q_exp;
    logic [CFGW-1:0] keep;
    rst_n     = 1'b0;
    cfg_we    = 1'b0;
    cfg_wdata = '0;
    clr       = 1'b0;
    face_in   = 4'h0;
    bus_in    = 2'b00;
    #1;
    chk("R1 reset face_oe", {28'd0, face_oe}, 32'd0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk("R1 face_oe", {28'd0, face_oe}, 32'd0);
    chk("R1 face_out", {28'd0, face_out}, 32'd0);
    chk("R1 bus_oe", {30'd0, bus_oe}, 32'd0);
    chk("R1 bus_out", {30'd0, bus_out}, 32'd0);
    chk("R1 cfg_err", {31'd0, cfg_err}, 32'd0);

    // R3: every truth table against every operand pair
    for (int t = 0; t < 16; t++) begin
      write_cfg(fu_cfg(4'(t), 2'b00, 1'b0, 2'b00, 2'b00));
      chk("R6 south oe", {28'd0, face_oe}, 32'h4);
      for (int ab = 0; ab < 4; ab++) begin
        face_in = {2'b00, 2'(ab >> 1), 1'(ab)};
        face_in = 4'(((ab >> 1) & 1) << 1 | (ab & 1));
        #1;
        chk("R3 lut2 result", {31'd0, face_out[2]}, 32'((t >> ab) & 1));
        chk("R7 fu source", {28'd0, face_out & 4'b1011}, 32'd0);
      end
    end

    // R3 half adder: sum (xor) and carry (and)
    write_cfg(fu_cfg(4'b0110, 2'b00, 1'b0, 2'b00, 2'b00));
    for (int ab = 0; ab < 4; ab++) begin
      face_in = 4'(ab);
      #1;
      chk("R3 half-adder sum", {31'd0, face_out[2]}, 32'(((ab >> 1) + (ab & 1)) & 1));
    end
    write_cfg(fu_cfg(4'b1000, 2'b00, 1'b0, 2'b00, 2'b00));
    for (int ab = 0; ab < 4; ab++) begin
      face_in = 4'(ab);
      #1;
      chk("R3 half-adder carry", {31'd0, face_out[2]}, 32'(((ab >> 1) + (ab & 1)) >> 1));
    end

    // R2: word without cfg_we is ignored
    keep = fu_cfg(4'b1000, 2'b00, 1'b0, 2'b00, 2'b00);
    @(negedge clk);
    cfg_wdata = fu_cfg(4'b0111, 2'b00, 1'b0, 2'b00, 2'b00);
    face_in   = 4'b0001;
    repeat (2) @(negedge clk);
    #1;
    chk("R2 hold without we", {31'd0, face_out[2]}, 32'd0);
    write_cfg(keep ^ 31'h7);
    #1;
    chk("R2 load on we", {31'd0, face_out[2]}, 32'd1);

    // R7/R8: pass-through from every face to every face
    for (int f = 0; f < 4; f++) begin
      for (int s = 0; s < 4; s++) begin
        write_cfg(mk(4'h0, 2'b00, 2'd0, 2'd1, 1'b0, 2'b00, 2'b00,
                     4'(1 << f), 12'(s << (3*f))));
        chk("R6 single output oe", {28'd0, face_oe}, 32'(1 << f));
        chk("R8 self select flag", {31'd0, cfg_err}, 32'(s == f));
        for (int p = 0; p < 16; p++) begin
          face_in = 4'(p);
          #1;
          chk(s == f ? "R8 self select out" : "R7 pass-through",
              {31'd0, face_out[f]}, (s == f) ? 32'd0 : 32'((p >> s) & 1));
        end
      end
    end
    // R8: source face that is itself an output
    write_cfg(mk(4'h0, 2'b00, 2'd0, 2'd1, 1'b0, 2'b00, 2'b00,
                 4'b0101, 12'b000_100_000_010));
    face_in = 4'hF;
    #1;
    chk("R8 output-face source", {31'd0, face_out[0]}, 32'd0);
    chk("R8 output-face flag", {31'd0, cfg_err}, 32'd1);

    // R4: multiplexer select through the bus pass gates
    for (int mb = 0; mb < 2; mb++) begin
      for (int pg = 0; pg < 4; pg++) begin
        write_cfg(fu_cfg(4'h0, 2'b01, 1'(mb), 2'(pg), 2'b00));
        for (int v = 0; v < 16; v++) begin
          logic sel;
          bus_in  = 2'(v >> 2);
          face_in = 4'(v & 3);
          sel     = ((pg >> mb) & 1) && ((v >> (2 + mb)) & 1);
          #1;
          chk("R4 mux2 result", {31'd0, face_out[2]},
              sel ? 32'((v >> 1) & 1) : 32'(v & 1));
        end
        chk("R4 no error", {31'd0, cfg_err}, 32'd0);
      end
    end
    bus_in = 2'b00;

    // R5: flip-flop capture, clear priority
    write_cfg(fu_cfg(4'h0, 2'b10, 1'b0, 2'b00, 2'b00));
    q_exp = 1'b0;
    for (int k = 0; k < 12; k++) begin
      logic d;
      logic c;
      d = 1'((k * 5 + 1) % 3 != 0);
      c = 1'(k % 4 == 3);
      face_in = {3'b000, d};
      clr     = c;
      @(posedge clk);
      q_exp = c ? 1'b0 : d;
      #2;
      chk(c ? "R5 clear priority" : "R5 capture", {31'd0, face_out[2]}, {31'd0, q_exp});
    end
    clr = 1'b0;
    // R5: hold while in another mode
    face_in = 4'b0001;
    write_cfg(fu_cfg(4'h0, 2'b00, 1'b0, 2'b00, 2'b00));
    face_in = 4'b0000;
    repeat (3) @(negedge clk);
    write_cfg(fu_cfg(4'h0, 2'b10, 1'b0, 2'b00, 2'b00));
    #1;
    chk("R5 hold outside dff mode", {31'd0, face_out[2]}, 32'd1);
    @(posedge clk);
    #2;
    chk("R5 capture after hold", {31'd0, face_out[2]}, 32'd0);

    // R9: bus writes
    write_cfg(fu_cfg(4'hF, 2'b00, 1'b0, 2'b11, 2'b01));
    #1;
    chk("R9 write oe", {30'd0, bus_oe}, 32'h1);
    chk("R9 write value", {30'd0, bus_out}, 32'h1);
    chk("R9 no error", {31'd0, cfg_err}, 32'd0);
    write_cfg(fu_cfg(4'hF, 2'b00, 1'b0, 2'b00, 2'b11));
    #1;
    chk("R9 driver without gate", {30'd0, bus_oe}, 32'h0);
    write_cfg(fu_cfg(4'h0, 2'b01, 1'b0, 2'b11, 2'b11));
    face_in = 4'b0001;
    #1;
    chk("R9 clash suppresses write", {30'd0, bus_oe}, 32'h2);
    chk("R9 clash value", {30'd0, bus_out}, 32'h2);
    chk("R9 clash flag", {31'd0, cfg_err}, 32'd1);

    // R10: reserved mode
    write_cfg(fu_cfg(4'hF, 2'b11, 1'b0, 2'b00, 2'b00));
    face_in = 4'hF;
    #1;
    chk("R10 reserved result", {31'd0, face_out[2]}, 32'd0);
    chk("R10 reserved flag", {31'd0, cfg_err}, 32'd1);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule